// File: doc/BRIEF.md
# Stream Fractional Rate Limiter

This block sits in a packet stream path and caps the average throughput at a programmable fraction of the bus capacity. The fraction is given as a numerator over a denominator and is measured in bytes per byte slot. Every clock cycle offers one slot per byte lane of the bus. A beat costs as many bytes as it has enable bits set in its keep field. The block adds no latency and holds no storage for data. When it permits traffic, the stream passes straight through and only the two handshake signals are gated.

The block tracks credit in a signed accumulator. Each cycle adds `rate_num` times the lane count. Each accepted beat takes away `rate_denom` times its byte count. A mode input selects where stalls may fall. In stream mode the limiter may stall any beat while credit is negative. In frame mode it only holds back the start of a frame, and once a frame has begun it runs to its last beat without a stall. The rate and the mode are sampled live, so a new setting shapes the traffic that follows it.

Top module: `stream_rate_limiter`

## Requirements
- R1: While `rst` is high, `m_valid` and `s_ready` stay low. The credit restarts at zero, so a beat offered in the first cycle after reset is accepted when the sink is ready.
- R2: `m_valid` equals `s_valid` AND permit, and `s_ready` equals `m_ready` AND permit, in the same cycle. A transfer on the input side is always a transfer on the output side.
- R3: The data, keep and last fields of every beat reach the output unchanged and in their original order.
- R4: On every cycle out of reset, credit grows by `rate_num` × lanes. On a cycle that moves a beat, credit also shrinks by `rate_denom` × (number of set bits in `s_keep`).
- R5: With `frame_mode` = 0 (stream mode), permit is high exactly when credit ≥ 0, and a frame may be stalled between any two of its beats.
- R6: With `frame_mode` = 1 (frame mode), permit stays high from the accepted first beat of a frame until its beat with last set is accepted. A frame may only begin while credit ≥ 0.
- R7: Credit saturates at `BURST_BEATS` × `rate_denom` × lanes. With the defaults (8 lanes, ceiling of 2 beats) at a ratio of 1/4 after a long idle, exactly three full beats pass back to back before the first stall.
- R8: With an always-ready sink and an always-valid source, the measured rate (bytes per slot) stays within 10% of the programmed ratio for 1/1, 1/2, 1/10 and 2/3, in both modes.
- R9: A change of `rate_num`, `rate_denom` or `frame_mode` applies from the cycle in which it is seen. The credit built up under the old ratio is kept.
- R10: The user field is passed through on every beat, so a user flag on a frame's last beat arrives on that frame's last output beat.
- R11: R2 to R6 hold while the source withdraws `s_valid` between beats and the sink drops `m_ready`, at arbitrary times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_num | input | RATE_W | Credit earned per byte slot |
| rate_denom | input | RATE_W | Credit spent per byte moved |
| frame_mode | input | 1 | 1: stall only between frames; 0: stall anywhere |
| s_data | input | DATA_W | Input beat data |
| s_keep | input | DATA_W/8 | Input byte enables |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_last | input | 1 | Input beat ends a frame |
| s_user | input | USER_W | Input sideband |
| m_data | output | DATA_W | Output beat data |
| m_keep | output | DATA_W/8 | Output byte enables |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_last | output | 1 | Output beat ends a frame |
| m_user | output | USER_W | Output sideband |

## Verification
The hardest state to reach is a frame that begins with credit just above zero, in frame mode. The frame must then be carried far into debt with no stall, while the sink drops ready in the middle of it. After that, the start of the next frame must wait exactly until the debt is repaid. The stimulus reaches this state in two ways. Frame-mode runs use frames of up to 256 bytes at a low ratio with random sink pauses. The rate sweep also switches ratio and mode between bursts, so that debt left under one setting is repaid under the next. A behavioural credit model in the bench predicts the valid and ready outputs on every cycle of these runs.

// File: rtl/rlim_pkg.sv
package rlim_pkg;

    typedef enum logic {
        RL_STREAM = 1'b0,
        RL_FRAME  = 1'b1
    } rl_mode_e;

    typedef struct packed {
        logic in_frame;
    } rl_gate_st_t;

endpackage

// File: rtl/rlim_lane_count.sv
module rlim_lane_count #(
    parameter int LANES = 8,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] lanes,
    output logic [CNT_W-1:0] count
);

    generate
        if (LANES == 1) begin : g_single
            assign count = lanes;
        end else begin : g_multi
            always_comb begin
                count = '0;
                for (int i = 0; i < LANES; i++) begin
                    count = count + CNT_W'(lanes[i]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rlim_credit.sv
module rlim_credit #(
    parameter int RATE_W          = 8,
    parameter int LANES           = 8,
    parameter int BURST_BEATS     = 2,
    parameter int MAX_FRAME_BYTES = 4096,
    parameter int CNT_W           = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] rate_num,
    input  logic [RATE_W-1:0] rate_denom,
    input  logic              take,
    input  logic [CNT_W-1:0]  take_bytes,
    output logic              credit_ok
);

    localparam int CW = RATE_W + $clog2(MAX_FRAME_BYTES + 1) + 3;
    localparam logic signed [CW-1:0] FLOOR = {2'b11, {(CW-2){1'b0}}};

    typedef struct packed {
        logic signed [CW-1:0] credit;
    } cr_st_t;

    cr_st_t st_d, st_q;
    logic [CW-1:0]        earn_u, cost_u;
    logic signed [CW-1:0] ceil_s, sum_s;

    always_comb begin
        st_d   = st_q;
        earn_u = CW'(rate_num) * CW'(LANES);
        cost_u = take ? CW'(rate_denom) * CW'(take_bytes) : '0;
        ceil_s = $signed(CW'(rate_denom) * CW'(LANES * BURST_BEATS));
        sum_s  = st_q.credit + $signed(earn_u) - $signed(cost_u);
        if (sum_s > ceil_s) begin
            st_d.credit = ceil_s;
        end else if (sum_s < FLOOR) begin
            st_d.credit = FLOOR;
        end else begin
            st_d.credit = sum_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign credit_ok = ~st_q.credit[CW-1];

    a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> st_q.credit == '0);

    a_r7_credit_ceiling: assert property (@(posedge clk) disable iff (rst)
        st_q.credit <= $past(ceil_s));

endmodule

// File: rtl/rlim_gate.sv
module rlim_gate
    import rlim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rl_mode_e mode,
    input  logic     credit_ok,
    input  logic     beat_xfer,
    input  logic     beat_last,
    output logic     permit
);

    rl_gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (beat_xfer) begin
            st_d.in_frame = ~beat_last;
        end
        permit = ~rst & (((mode == RL_FRAME) & st_q.in_frame) | credit_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stream_rate_limiter.sv
module stream_rate_limiter
    import rlim_pkg::*;
#(
    parameter int DATA_W          = 64,
    parameter int USER_W          = 1,
    parameter int RATE_W          = 8,
    parameter int BURST_BEATS     = 2,
    parameter int MAX_FRAME_BYTES = 4096
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [RATE_W-1:0]   rate_num,
    input  logic [RATE_W-1:0]   rate_denom,
    input  logic                frame_mode,
    input  logic [DATA_W-1:0]   s_data,
    input  logic [DATA_W/8-1:0] s_keep,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic                s_last,
    input  logic [USER_W-1:0]   s_user,
    output logic [DATA_W-1:0]   m_data,
    output logic [DATA_W/8-1:0] m_keep,
    output logic                m_valid,
    input  logic                m_ready,
    output logic                m_last,
    output logic [USER_W-1:0]   m_user
);

    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = $clog2(LANES + 1);

    logic             permit;
    logic             credit_ok;
    logic             beat_xfer;
    logic [CNT_W-1:0] beat_bytes;

    rlim_lane_count #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_count (
        .lanes (s_keep),
        .count (beat_bytes)
    );

    rlim_credit #(
        .RATE_W          (RATE_W),
        .LANES           (LANES),
        .BURST_BEATS     (BURST_BEATS),
        .MAX_FRAME_BYTES (MAX_FRAME_BYTES),
        .CNT_W           (CNT_W)
    ) u_credit (
        .clk        (clk),
        .rst        (rst),
        .rate_num   (rate_num),
        .rate_denom (rate_denom),
        .take       (beat_xfer),
        .take_bytes (beat_bytes),
        .credit_ok  (credit_ok)
    );

    rlim_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .mode      (rl_mode_e'(frame_mode)),
        .credit_ok (credit_ok),
        .beat_xfer (beat_xfer),
        .beat_last (s_last),
        .permit    (permit)
    );

    assign beat_xfer = s_valid & m_ready & permit;
    assign m_valid   = s_valid & permit;
    assign s_ready   = m_ready & permit;
    assign m_data    = s_data;
    assign m_keep    = s_keep;
    assign m_last    = s_last;
    assign m_user    = s_user;

    a_r2_valid_follows_input: assert property (@(posedge clk) disable iff (rst)
        m_valid |-> s_valid);

    a_r2_ready_follows_sink: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> m_ready);

    a_r5_stream_blocks_on_debt: assert property (@(posedge clk) disable iff (rst)
        (!frame_mode && !credit_ok) |-> !m_valid);

    a_r6_no_mid_frame_stall: assert property (@(posedge clk) disable iff (rst)
        (frame_mode && $past(frame_mode) && $past(s_valid && s_ready && !s_last)
         && s_valid && m_ready) |-> s_ready);

endmodule

// File: tb/stream_rate_limiter_tb_top.sv
module stream_rate_limiter_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DW = 64;
    localparam int KW = DW / 8;
    localparam int RW = 8;
    localparam int BB = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] rate_num = 8'd1;
    logic [RW-1:0] rate_denom = 8'd4;
    logic          frame_mode = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic [KW-1:0] s_keep = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic          s_last = 1'b0;
    logic [0:0]    s_user = '0;
    logic [DW-1:0] m_data;
    logic [KW-1:0] m_keep;
    logic          m_valid;
    logic          m_ready = 1'b0;
    logic          m_last;
    logic [0:0]    m_user;

    stream_rate_limiter #(
        .DATA_W (DW), .USER_W (1), .RATE_W (RW), .BURST_BEATS (BB), .MAX_FRAME_BYTES (4096)
    ) dut_i (
        .clk (clk), .rst (rst), .rate_num (rate_num), .rate_denom (rate_denom),
        .frame_mode (frame_mode),
        .s_data (s_data), .s_keep (s_keep), .s_valid (s_valid), .s_ready (s_ready),
        .s_last (s_last), .s_user (s_user),
        .m_data (m_data), .m_keep (m_keep), .m_valid (m_valid), .m_ready (m_ready),
        .m_last (m_last), .m_user (m_user)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [DW-1:0] d;
        logic [KW-1:0] k;
        bit            l;
        bit            u;
    } beat_t;

    beat_t bq[$];
    int    idx = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 0;
    int    credit = 0;
    bit    in_frame = 0;
    bit    presenting = 0;
    int    marker_idx = -1;
    int    first_xfer = -1;
    int    last_xfer = -1;
    longint bytes_meas = 0;
    bit    burst_on = 0;
    int    burst_cnt = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic add_frame(input int len, input int fid, input bit user);
        int nb = (len + KW - 1) / KW;
        for (int b = 0; b < nb; b++) begin
            beat_t bt;
            int rem = len - b * KW;
            for (int l = 0; l < KW; l++) bt.d[l*8 +: 8] = 8'((fid * 37 + b * KW + l) & 255);
            bt.k = (rem >= KW) ? {KW{1'b1}} : KW'((1 << rem) - 1);
            bt.l = (b == nb - 1);
            bt.u = bt.l & user;
            bq.push_back(bt);
        end
    endtask

    // One cycle: entered at a falling edge, leaves at the next falling edge.
    task automatic step(input int src_idle, input int sink_idle, input string tag);
        bit permit, xv;
        int nb;
        if (!presenting && idx < bq.size() && $urandom_range(99) >= src_idle) begin
            presenting = 1;
            s_data = bq[idx].d; s_keep = bq[idx].k; s_last = bq[idx].l; s_user = bq[idx].u;
        end
        s_valid = presenting;
        m_ready = ($urandom_range(99) >= sink_idle);
        #1;
        permit = (frame_mode && in_frame) || credit >= 0;
        check(m_valid === (s_valid && permit), tag, "out valid", longint'(m_valid),
              longint'(s_valid && permit));
        check(s_ready === (m_ready && permit), tag, "in ready", longint'(s_ready),
              longint'(m_ready && permit));
        xv = s_valid && m_ready && permit;
        if (xv) begin
            check(m_data === bq[idx].d && m_keep === bq[idx].k && m_last === bq[idx].l,
                  "R3", "beat content", longint'(m_data), longint'(bq[idx].d));
            check(m_user === bq[idx].u, "R10", "user flag", longint'(m_user), longint'(bq[idx].u));
        end
        if (burst_on && s_valid && m_ready) begin
            if (s_ready) burst_cnt++;
            else burst_on = 0;
        end
        nb = $countones(s_keep);
        @(posedge clk);
        credit = credit + int'(rate_num) * KW - (xv ? int'(rate_denom) * nb : 0);
        if (credit > BB * int'(rate_denom) * KW) credit = BB * int'(rate_denom) * KW;
        if (xv) begin
            in_frame = !s_last;
            if (first_xfer < 0) first_xfer = cyc;
            if (idx == marker_idx) last_xfer = cyc;
            else bytes_meas += nb;
            idx++;
            presenting = 0;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic run(input int si, input int ki, input string tag);
        while (idx < bq.size()) step(si, ki, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, tag);
    endtask

    task automatic load(input bit with_marker);
        int lens[8] = '{32, 48, 64, 96, 128, 256, 35, 13};
        bq.delete();
        idx = 0;
        for (int f = 0; f < (with_marker ? 6 : 8); f++) add_frame(lens[f], f + 1, f[0]);
        marker_idx = -1;
        if (with_marker) begin
            add_frame(1, 99, 1'b0);
            marker_idx = bq.size() - 1;
        end
        first_xfer = -1; last_xfer = -1; bytes_meas = 0;
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int rates[4][2] = '{'{1, 1}, '{1, 2}, '{1, 10}, '{2, 3}};
        @(negedge clk);
        // Reset holds both handshakes low even with traffic offered
        s_valid = 1; m_ready = 1; s_keep = '1;
        for (int i = 0; i < 4; i++) begin
            #1;
            check(m_valid === 1'b0 && s_ready === 1'b0, "R1", "handshake in reset",
                  longint'({m_valid, s_ready}), 0);
            @(negedge clk);
        end
        rst = 0; s_valid = 0;
        credit = 0; in_frame = 0;

        // Stream mode at 1/4 with random pauses on both sides; R1 first beat at zero credit
        load(1'b0);
        run(30, 30, "R1 R2 R4 R5 R11");
        idle(20, "R4");

        // Frame mode at 1/4 with pauses
        frame_mode = 1;
        load(1'b0);
        run(30, 30, "R2 R4 R6 R11");
        idle(20, "R4");

        // Frame mode at 1/10 with sink-only pauses: deep debt inside frames
        rate_denom = 8'd10;
        load(1'b0);
        run(0, 40, "R6 R9 R11");

        // Rate sweep in both modes
        for (int m = 1; m >= 0; m--) begin
            for (int r = 0; r < 4; r++) begin
                real meas, want;
                frame_mode = m[0];
                rate_num = 8'(rates[r][0]);
                rate_denom = 8'(rates[r][1]);
                idle(30, "R9");
                load(1'b1);
                run(0, 0, "R4 R9");
                meas = real'(bytes_meas) / real'((last_xfer - first_xfer) * KW);
                want = real'(rates[r][0]) / real'(rates[r][1]);
                check((meas - want) < 0.1 * want && (want - meas) < 0.1 * want, "R8",
                      "rate x1000", longint'(meas * 1000.0), longint'(want * 1000.0));
            end
        end

        // Ceiling: after a long idle at 1/4 only three full beats pass unstalled
        frame_mode = 0;
        rate_num = 8'd1;
        rate_denom = 8'd4;
        idle(40, "R7");
        load(1'b0);
        bq.delete();
        add_frame(64, 5, 1'b0);
        burst_on = 1; burst_cnt = 0;
        run(0, 0, "R5 R7");
        check(burst_cnt == 3, "R7", "beats before first stall", burst_cnt, 3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule